// File: doc/BRIEF.md
# DRAM Refresh and Initialization Controller

This block owns the control strobes of an asynchronous DRAM whenever the memory must be woken up or refreshed. After reset it keeps every strobe inactive for a power-up pause of at least 200 µs. It then runs a fixed burst of eight wake-up refresh cycles and raises `ready`. From then on an interval timer asks for one refresh per slot, so that the whole array is refreshed once per 64 ms retention window.

A build parameter selects the refresh flavour. In the column-strobe-first variant the memory's own row counter is used, and 4096 cycles cover one window (one cycle every 3906 clocks at 4 ns). In the row-only variant the block drives a row address from its own wrapping counter, and 2^ROW_W rows cover one window (8192 rows, one cycle every 1953 clocks). The write-enable strobe is held inactive at all times, so a refresh can never enter the parallel test mode of the memory.

A host access port shares the strobes. `host_req` behaves as a valid and `host_gnt` as a ready. A grant is given only when the controller is idle and initialized. Once given, it is held for as long as the host keeps `host_req` high, and it drops on the cycle after the request falls. Refresh slots that fall during a host tenure are queued, up to eight. With eight slots queued, no new grant is issued until the queue has been drained below eight. While the queue is not full, a waiting host request wins over queued refreshes.

Top module: `rfc_ctrl`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1, `ready` and `host_gnt` are 0, and `busy` is 1.
- R2: No strobe goes low before PAUSE_NS / CLK_NS clock cycles have passed since reset was released (50000 cycles with the default parameters).
- R3: Exactly WAKE_CNT (8) refresh cycles (`ras_n` falling edges) occur before `ready` rises, and once `ready` is 1 it stays 1.
- R4: In the column-strobe-first variant (RAS_ONLY=0), `cas_n` is low for at least T_CSR (2) cycles before each fall of `ras_n`, and stays low while `ras_n` is low.
- R5: `we_n` is 1 in every cycle.
- R6: In the row-only variant (RAS_ONLY=1), `cas_n` stays 1, and `addr` at each fall of `ras_n` carries the row number. Rows start at 0 after reset and step by one per cycle, wrapping at 2^ROW_W.
- R7: `ras_n` stays low for at least T_RAS (15) cycles per refresh, and stays high for at least T_RP (10) cycles between refreshes.
- R8: After `ready`, refreshes occur at one per interval: RETAIN_NS / (rows per window × CLK_NS) cycles, which is 3906 for the column-strobe-first variant and 1953 for the row-only variant.
- R9: `host_gnt` is 1 only while `busy` is 0. A grant stays high while `host_req` is held and falls one cycle after `host_req` falls. No refresh starts while the host holds the grant.
- R10: Up to QUEUE_MAX (8) refresh slots are queued during a host tenure. With the queue full, no new grant is given before one queued refresh has run.
- R11: Queued refreshes run back to back once the host releases the strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host asks for the strobes (valid) |
| host_gnt | output | 1 | Host owns the strobes (ready) |
| ready | output | 1 | Initialization finished |
| busy | output | 1 | Controller owns the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row address for row-only refresh |

## Verification
The hardest state to reach is a full refresh queue: it needs a host that holds the strobes across eight refresh slots without reaching a ninth. The bench raises `host_req` right after the rate-measurement window and holds it for eight and a quarter intervals. It then drops the request for one cycle and raises it again. Exactly one refresh must come before the new grant, and the remaining seven must drain back to back once the host lets go. In parallel, a scoreboard compares the row sequence of a row-only instance against expected rows pushed by a driver task.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_ACT, SQ_PRE} sq_state_e;
endpackage

// File: rtl/rfc_tick.sv
module rfc_tick #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/rfc_pending.sv
module rfc_pending #(
  parameter int QMAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic full,
  output logic nonempty
);
  localparam int CW = $clog2(QMAX + 1);
  localparam logic [CW-1:0] TOP = CW'(QMAX);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else begin
      case ({inc && (cnt != TOP), dec && (cnt != '0)})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign full = (cnt == TOP);
  assign nonempty = (cnt != '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> nonempty); // R10
endmodule

// File: rtl/rfc_seq.sv
module rfc_seq
  import rfc_pkg::*;
#(
  parameter bit RAS_ONLY = 1'b0,
  parameter int ROW_W    = 13,
  parameter int T_CSR    = 2,
  parameter int T_RAS    = 15,
  parameter int T_RP     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             idle,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr
);
  localparam int TMAX = (T_RAS > T_RP) ? ((T_RAS > T_CSR) ? T_RAS : T_CSR)
                                       : ((T_RP > T_CSR) ? T_RP : T_CSR);
  localparam int TW = $clog2(TMAX + 1);

  sq_state_e        state;
  logic [TW-1:0]    tcnt;
  logic [ROW_W-1:0] row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      tcnt  <= '0;
      row   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      addr  <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state <= SQ_SETUP;
          tcnt  <= TW'(T_CSR - 1);
          if (RAS_ONLY) addr <= row;
          else cas_n <= 1'b0;
        end
        SQ_SETUP: if (tcnt == '0) begin
          state <= SQ_ACT;
          ras_n <= 1'b0;
          tcnt  <= TW'(T_RAS - 1);
        end else tcnt <= tcnt - 1'b1;
        SQ_ACT: if (tcnt == '0) begin
          state <= SQ_PRE;
          ras_n <= 1'b1;
          cas_n <= 1'b1;
          tcnt  <= TW'(T_RP - 1);
          if (RAS_ONLY) row <= row + 1'b1;
        end else tcnt <= tcnt - 1'b1;
        default: if (tcnt == '0) state <= SQ_IDLE;
                 else tcnt <= tcnt - 1'b1;
      endcase
    end
  end

  assign idle = (state == SQ_IDLE);

  // separate run-length counters for the strobe width checks
  logic [15:0] low_run, high_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= 16'hffff;
    end else begin
      low_run  <= ras_n ? '0 : ((low_run == 16'hffff) ? low_run : low_run + 1'b1);
      high_run <= !ras_n ? '0 : ((high_run == 16'hffff) ? high_run : high_run + 1'b1);
    end
  end

  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_run >= 16'(T_RAS))); // R7
  AST_RAS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_run >= 16'(T_RP))); // R7

  generate
    if (!RAS_ONLY) begin : g_cbr_chk
      AST_CAS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n) && $past(!cas_n, 2))); // R4
      AST_CAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> !cas_n); // R4
    end
  endgenerate
endmodule

// File: rtl/rfc_ctrl.sv
module rfc_ctrl #(
  parameter int CLK_NS    = 4,
  parameter int PAUSE_NS  = 200_000,
  parameter int RETAIN_NS = 64_000_000,
  parameter int CBR_ROWS  = 4096,
  parameter int ROW_W     = 13,
  parameter int WAKE_CNT  = 8,
  parameter int QUEUE_MAX = 8,
  parameter int T_CSR     = 2,
  parameter int T_RAS     = 15,
  parameter int T_RP      = 10,
  parameter bit RAS_ONLY  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  output logic             host_gnt,
  output logic             ready,
  output logic             busy,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr
);
  localparam int PAUSE_CYC = (PAUSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int REF_ROWS  = RAS_ONLY ? (1 << ROW_W) : CBR_ROWS;
  localparam int INTERVAL  = RETAIN_NS / (REF_ROWS * CLK_NS);
  localparam int WW        = $clog2(WAKE_CNT + 1);

  logic          pause_tick, pause_done;
  logic          slot_tick;
  logic          pend_full, pend_ne;
  logic          seq_idle, start, host_own;
  logic [WW-1:0] wake_left;

  rfc_tick #(.PERIOD(PAUSE_CYC)) u_pause (
    .clk(clk), .rst_n(rst_n), .en(!pause_done), .tick(pause_tick));

  rfc_tick #(.PERIOD(INTERVAL)) u_slot (
    .clk(clk), .rst_n(rst_n), .en(ready), .tick(slot_tick));

  rfc_pending #(.QMAX(QUEUE_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(slot_tick), .dec(start && ready),
    .full(pend_full), .nonempty(pend_ne));

  rfc_seq #(.RAS_ONLY(RAS_ONLY), .ROW_W(ROW_W), .T_CSR(T_CSR),
            .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .idle(seq_idle),
    .ras_n(ras_n), .cas_n(cas_n), .addr(addr));

  logic init_go, ref_go;
  always_comb begin
    init_go = pause_done && !ready && (wake_left != '0);
    ref_go  = ready && pend_ne && (!host_req || pend_full);
    start   = seq_idle && !host_own && (init_go || ref_go);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_done <= 1'b0;
      wake_left  <= WW'(WAKE_CNT);
      ready      <= 1'b0;
      host_own   <= 1'b0;
    end else begin
      if (pause_tick) pause_done <= 1'b1;
      if (start && !ready) wake_left <= wake_left - 1'b1;
      if (pause_done && (wake_left == '0) && seq_idle) ready <= 1'b1;
      if (host_own) host_own <= host_req;
      else host_own <= seq_idle && !start && ready && host_req && !pend_full;
    end
  end

  assign host_gnt = host_own;
  assign busy     = !ready || !seq_idle;
  assign we_n     = 1'b1;

  AST_QUIET_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_done |-> (ras_n && cas_n)); // R2
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R3
  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> (!busy && ras_n && cas_n)); // R9
  AST_NO_GNT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_gnt) |-> $past(!pend_full)); // R10
endmodule

// File: tb/tb_rfc_ctrl.sv
module tb_rfc_ctrl;
  localparam int ROW_W  = 13;
  localparam int IV_CBR = 3906;
  localparam int IV_RO  = 1953;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic c_req = 1'b0;
  logic c_gnt, c_ready, c_busy, c_ras, c_cas, c_we;
  logic [ROW_W-1:0] c_addr;
  logic r_gnt, r_ready, r_busy, r_ras, r_cas, r_we;
  logic [ROW_W-1:0] r_addr;

  rfc_ctrl #(.RAS_ONLY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(c_req), .host_gnt(c_gnt),
    .ready(c_ready), .busy(c_busy), .ras_n(c_ras), .cas_n(c_cas),
    .we_n(c_we), .addr(c_addr));

  rfc_ctrl #(.RAS_ONLY(1'b1)) dut_ro (
    .clk(clk), .rst_n(rst_n), .host_req(1'b0), .host_gnt(r_gnt),
    .ready(r_ready), .busy(r_busy), .ras_n(r_ras), .cas_n(r_cas),
    .we_n(r_we), .addr(r_addr));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard for row-only addresses
  int exp_rows[$];
  task automatic push_rows(input int n);
    for (int i = 0; i < n; i++) exp_rows.push_back(i % (1 << ROW_W));
  endtask

  longint cyc = 0;
  longint first_act = -1;
  int c_falls = 0, r_falls = 0;
  int cbr_viol = 0, we_viol = 0, ro_cas_viol = 0, rdy_drop = 0;
  int c_low = 0, r_low = 0, c_high = 0, r_high = 0;
  int min_low = 1000, min_high = 1000;
  logic c_ras_q = 1'b1, r_ras_q = 1'b1, c_rdy_q = 1'b0, r_rdy_q = 1'b0;
  logic [1:0] c_cas_h = 2'b11;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (first_act < 0 && (!c_ras || !c_cas)) first_act = cyc;
      if (!c_we || !r_we) we_viol++;
      if (!r_cas) ro_cas_viol++;
      if ((c_rdy_q && !c_ready) || (r_rdy_q && !r_ready)) rdy_drop++;
      if (c_ras_q && !c_ras) begin
        c_falls++;
        if (c_cas || c_cas_h != 2'b00) cbr_viol++;
        if (c_falls > 1 && c_high < min_high) min_high = c_high;
      end
      if (!c_ras && !c_cas_h[0] && c_cas) cbr_viol++;
      if (!c_ras_q && c_ras && c_low < min_low) min_low = c_low;
      if (r_ras_q && !r_ras) begin
        r_falls++;
        if (r_falls > 1 && r_high < min_high) min_high = r_high;
        if (exp_rows.size() > 0) begin
          int e;
          e = exp_rows.pop_front();
          chk(r_addr == e[ROW_W-1:0], "R6", "row address", r_addr, e);
        end
      end
      if (!r_ras_q && r_ras && r_low < min_low) min_low = r_low;
      c_low  = c_ras ? 0 : c_low + 1;
      r_low  = r_ras ? 0 : r_low + 1;
      c_high = c_ras ? c_high + 1 : 0;
      r_high = r_ras ? r_high + 1 : 0;
      c_ras_q = c_ras; r_ras_q = r_ras;
      c_cas_h = {c_cas_h[0], c_cas};
      c_rdy_q = c_ready; r_rdy_q = r_ready;
    end
  end

  initial begin
    int f0, g0, waitc;
    push_rows(64);
    repeat (10) @(negedge clk);
    chk(c_ras && c_cas && c_we && !c_ready && c_busy && !c_gnt, "R1",
        "reset state cbr", {c_ras, c_cas, c_we, c_ready, c_busy, c_gnt}, 6'b111010);
    chk(r_ras && r_cas && r_we && !r_ready && r_busy && !r_gnt, "R1",
        "reset state ro", {r_ras, r_cas, r_we, r_ready, r_busy, r_gnt}, 6'b111010);
    rst_n = 1'b1;
    while (!(c_ready && r_ready)) @(negedge clk);
    chk(first_act >= 50000 && first_act <= 50010, "R2", "first strobe cycle",
        first_act, 50001);
    chk(c_falls == 8, "R3", "wake cycles cbr", c_falls, 8);
    chk(r_falls == 8, "R3", "wake cycles ro", r_falls, 8);
    f0 = c_falls; g0 = r_falls;
    repeat (10 * IV_CBR + 100) @(negedge clk);
    chk(c_falls - f0 == 10, "R8", "cbr refreshes in window", c_falls - f0, 10);
    chk(r_falls - g0 == 20, "R8", "ro refreshes in window", r_falls - g0, 20);
    // host tenure
    c_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(c_gnt && !c_busy, "R9", "grant while idle", {c_gnt, c_busy}, 2'b10);
    f0 = c_falls;
    repeat (8 * IV_CBR + 1000) @(negedge clk);
    chk(c_falls == f0, "R9", "no refresh during tenure", c_falls - f0, 0);
    chk(c_gnt, "R9", "grant held", c_gnt, 1);
    c_req = 1'b0;
    @(negedge clk);
    chk(!c_gnt, "R9", "grant drops after request", c_gnt, 0);
    c_req = 1'b1;
    f0 = c_falls;
    waitc = 0;
    while (!c_gnt && waitc < 300) begin @(negedge clk); waitc++; end
    chk(c_falls - f0 == 1, "R10", "refreshes before regrant with full queue",
        c_falls - f0, 1);
    c_req = 1'b0;
    repeat (7 * 28 + 40) @(negedge clk);
    chk(c_falls - f0 == 8, "R11", "queued refreshes drained", c_falls - f0, 8);
    chk(cbr_viol == 0, "R4", "cas setup/hold violations", cbr_viol, 0);
    chk(we_viol == 0, "R5", "we_n low samples", we_viol, 0);
    chk(ro_cas_viol == 0, "R6", "cas low in row-only", ro_cas_viol, 0);
    chk(min_low >= 15, "R7", "min ras low width", min_low, 15);
    chk(min_high >= 10, "R7", "min ras precharge", min_high, 10);
    chk(rdy_drop == 0, "R3", "ready drops", rdy_drop, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule